// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation inside the device has finished. It does this by reading a status byte at one address again and again and watching the completion bit.

A single start pulse loads three things: the address to poll, the expected data byte and an erase flag. The block then issues reads on a simple request/acknowledge read port, one read for each acknowledge. It always uses the address it loaded.

- **Completion bit matches:** when bit 7 of a status read equals the expected bit 7, the block makes one further read to collect a byte whose eight bits have all settled. It then reports a pass.
- **Completion bit differs, timeout bit clear:** the block keeps polling.
- **Completion bit differs, timeout bit set:** the block makes exactly one more read and tests the completion bit again. The two bits may have changed together, so this second look decides pass or fail.

An optional limit on the number of ordinary polls ends a run that never finishes with a fail. Each run ends with a one-cycle done pulse. The pass flag and the final byte are held until the next run.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle: rd_req_o is 0 and done_o is 0.
- R2: Every read of a run presents on rd_addr_o the address sampled with start_i, and that address stays unchanged while a request waits for its acknowledge.
- R3: When bit 7 of a status read equals the expected bit, the block issues exactly one further read. In the cycle after that read is acknowledged, it raises done_o with pass_o = 1 and data_o equal to the byte returned by that further read.
- R4: When bit 7 of a status read differs from the expected bit and bit 5 is 0, the block does not finish: in the next cycle done_o is 0 and rd_req_o is 1.
- R5: When bit 7 differs and bit 5 is 1, the block issues exactly one recheck read. If bit 7 of the recheck matches, the block proceeds as in R3: one more read, then a pass.
- R6: If bit 7 of the recheck read still differs, the block raises done_o in the next cycle with pass_o = 0 and data_o equal to the recheck byte. It issues no further read.
- R7: With erase_i = 1 at start, the expected completion bit is 1, whatever exp_data_i holds. With erase_i = 0, it is bit 7 of exp_data_i.
- R8: done_o is high for exactly one cycle per run, and the block returns to idle afterwards. A start_i pulse while a run is active is ignored, and the address and the sequence of the run are unchanged.
- R9: When MAX_POLLS is non-zero and MAX_POLLS status reads in a row each show a bit-7 mismatch with bit 5 clear, the block fails. done_o rises in the next cycle with pass_o = 0 and data_o equal to the last byte read.
- R10: Once rd_req_o is raised, it stays high until a cycle in which rd_ack_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| erase_i | input | 1 | 1: erase polling (expected bit 7 is 1); 0: program polling |
| exp_data_i | input | DATA_W | Byte that was programmed |
| addr_i | input | ADDR_W | Address to poll |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid with rd_ack_i |
| rd_ack_i | input | 1 | Read done; one cycle per read |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run |
| data_o | output | DATA_W | Final byte of the last run |

## Verification
The properties assume the following about the read port:
- rd_ack_i is raised only while rd_req_o is high.
- rd_ack_i lasts a single cycle.
- rd_data_i is valid in that cycle.

The stimulus keeps to this. It raises an acknowledge only after seeing a request at a falling edge, and it drops the acknowledge at the next falling edge. It also pulses start_i while idle, except for the one deliberate pulse during a waiting read.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_POLL  = 3'd1,
      PS_RECHK = 3'd2,
      PS_CAPT  = 3'd3,
      PS_DONE  = 3'd4
   } poll_state_t;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TMO_BIT  = 5
) (
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              exp_bit_i,
   output logic              match_o,
   output logic              tmo_o
);
   initial begin
      if (POLL_BIT >= DATA_W || TMO_BIT >= DATA_W || POLL_BIT == TMO_BIT)
         $error("flash_poll_eval: bad bit positions");
   end

   always_comb begin
      match_o = (rd_data_i[POLL_BIT] == exp_bit_i);
      tmo_o   = rd_data_i[TMO_BIT];
   end
endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
   parameter int MAX_POLLS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);
   initial begin
      if (MAX_POLLS < 0) $error("flash_poll_limit: MAX_POLLS must be >= 0");
   end

   generate
      if (MAX_POLLS == 0) begin : g_unlimited
         logic unused_lim;
         assign unused_lim = &{1'b0, clk, rst_n, clr_i, inc_i};
         assign hit_o = 1'b0;
      end else begin : g_limited
         localparam int CNT_W = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) cnt_q <= '0;
            else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end

         assign hit_o = inc_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
   import flash_poll_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ack_i,
   input  logic match_i,
   input  logic tmo_i,
   input  logic limit_hit_i,
   output logic accept_o,
   output logic poll_miss_o,
   output logic rd_req_o,
   output logic done_o,
   output logic load_res_o,
   output logic res_pass_o
);
   poll_state_t st_q, st_d;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= PS_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      load_res_o  = 1'b0;
      res_pass_o  = 1'b0;
      poll_miss_o = 1'b0;
      case (st_q)
         PS_IDLE: if (start_i) st_d = PS_POLL;
         PS_POLL: if (ack_i) begin
            if (match_i)    st_d = PS_CAPT;
            else if (tmo_i) st_d = PS_RECHK;
            else begin
               poll_miss_o = 1'b1;
               if (limit_hit_i) begin
                  st_d       = PS_DONE;
                  load_res_o = 1'b1;
               end
            end
         end
         PS_RECHK: if (ack_i) begin
            if (match_i) st_d = PS_CAPT;
            else begin
               st_d       = PS_DONE;
               load_res_o = 1'b1;
            end
         end
         PS_CAPT: if (ack_i) begin
            st_d       = PS_DONE;
            load_res_o = 1'b1;
            res_pass_o = 1'b1;
         end
         PS_DONE: st_d = PS_IDLE;
         default: st_d = PS_IDLE;
      endcase
   end

   assign accept_o = (st_q == PS_IDLE) && start_i;
   assign rd_req_o = (st_q == PS_POLL) || (st_q == PS_RECHK) || (st_q == PS_CAPT);
   assign done_o   = (st_q == PS_DONE);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int POLL_BIT  = 7,
   parameter int TMO_BIT   = 5,
   parameter int MAX_POLLS = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              erase_i,
   input  logic [DATA_W-1:0] exp_data_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_ack_i,
   output logic              done_o,
   output logic              pass_o,
   output logic [DATA_W-1:0] data_o
);
   initial begin
      if (ADDR_W < 1 || DATA_W < 2) $error("flash_poll_ctrl: bad widths");
   end

   logic              exp_bit_q;
   logic              accept, poll_miss, limit_hit, match, tmo;
   logic              load_res, res_pass, ack_ok;

   assign ack_ok = rd_ack_i && rd_req_o;

   flash_poll_eval #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TMO_BIT(TMO_BIT)) u_eval (
      .rd_data_i (rd_data_i),
      .exp_bit_i (exp_bit_q),
      .match_o   (match),
      .tmo_o     (tmo)
   );

   flash_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .inc_i (poll_miss),
      .hit_o (limit_hit)
   );

   flash_poll_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .ack_i       (ack_ok),
      .match_i     (match),
      .tmo_i       (tmo),
      .limit_hit_i (limit_hit),
      .accept_o    (accept),
      .poll_miss_o (poll_miss),
      .rd_req_o    (rd_req_o),
      .done_o      (done_o),
      .load_res_o  (load_res),
      .res_pass_o  (res_pass)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_addr_o <= '0;
         exp_bit_q <= 1'b0;
         pass_o    <= 1'b0;
         data_o    <= '0;
      end else begin
         if (accept) begin
            rd_addr_o <= addr_i;
            exp_bit_q <= erase_i ? 1'b1 : exp_data_i[POLL_BIT];
         end
         if (load_res) begin
            pass_o <= res_pass;
            data_o <= rd_data_i;
         end
      end
   end
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              erase_i,
   input logic [DATA_W-1:0] exp_data_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              rd_ack_i,
   input logic              done_o,
   input logic              pass_o,
   input logic [DATA_W-1:0] data_o
);
   logic unused_chk;
   assign unused_chk = &{1'b0, erase_i, exp_data_i, addr_i, rd_data_i, pass_o, data_o};

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> rd_req_o); // R10
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o)); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && start_i) |=> $stable(rd_addr_o)); // R8
   AST_NO_REQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rd_req_o); // R6
   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(rd_ack_i && rd_req_o)); // R3
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_poll_ctrl_tb.sv
`timescale 1ns/1ps
module flash_poll_ctrl_tb;
   localparam int AW  = 19;
   localparam int DW  = 8;
   localparam int LIM = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, erase_i = 1'b0, rd_ack_i = 1'b0;
   logic [DW-1:0] exp_data_i = '0, rd_data_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic          rd_req_o, done_o, pass_o;
   logic [AW-1:0] rd_addr_o;
   logic [DW-1:0] data_o;

   int checks = 0, errors = 0;
   logic [7:0] rsp[$];

   always #2 clk = ~clk;

   flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
      .exp_data_i(exp_data_i), .addr_i(addr_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .rd_ack_i(rd_ack_i),
      .done_o(done_o), .pass_o(pass_o), .data_o(data_o));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference model: walks the response list and predicts the read count and result.
   function automatic void predict(input bit erase, input logic [7:0] exp,
                                   output int n, output bit pass, output logic [7:0] data);
      bit e;
      int misses;
      e = erase ? 1'b1 : exp[7];
      misses = 0;
      n = rsp.size(); pass = 1'b0; data = 8'h00;
      for (int i = 0; i < rsp.size(); i++) begin
         if (rsp[i][7] == e) begin
            n = i + 2; pass = 1'b1; data = rsp[i+1]; return;
         end
         if (rsp[i][5]) begin
            if (rsp[i+1][7] == e) begin n = i + 3; pass = 1'b1; data = rsp[i+2]; end
            else begin n = i + 2; pass = 1'b0; data = rsp[i+1]; end
            return;
         end
         misses++;
         if (misses == LIM) begin n = i + 1; pass = 1'b0; data = rsp[i]; return; end
      end
   endfunction

   task automatic run(input string tag, input bit erase, input logic [7:0] exp,
                      input logic [AW-1:0] a, input bit poke);
      int n; bit pass; logic [7:0] data;
      predict(erase, exp, n, pass, data);
      @(negedge clk);
      start_i = 1'b1; erase_i = erase; exp_data_i = exp; addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < n; k++) begin
         int lat;
         lat = (k * 2 + int'(exp[1:0])) % 3 + (poke ? 1 : 0);
         for (int j = 0; j < lat; j++) begin
            chk(rd_req_o == 1'b1, "R10", {tag, " request held"}, rd_req_o, 1);
            chk(rd_addr_o == a, "R2", {tag, " address"}, rd_addr_o, a);
            if (poke && k == 0 && j == 0) begin
               start_i = 1'b1; addr_i = ~a; erase_i = ~erase;
            end
            @(negedge clk);
            start_i = 1'b0;
         end
         chk(rd_req_o == 1'b1 && rd_addr_o == a, "R2", {tag, " request/address at ack"},
             rd_addr_o, a);
         rd_ack_i = 1'b1; rd_data_i = rsp[k];
         @(negedge clk);
         rd_ack_i = 1'b0; rd_data_i = 8'h00;
         if (k == n - 1) begin
            chk(done_o == 1'b1, "R3", {tag, " done raised"}, done_o, 1);
            chk(pass_o == pass, pass ? "R3" : "R6", {tag, " pass flag"}, pass_o, pass);
            chk(data_o == data, pass ? "R3" : "R6", {tag, " final byte"}, data_o, data);
            chk(rd_req_o == 1'b0, "R6", {tag, " no read with done"}, rd_req_o, 0);
         end else begin
            chk(done_o == 1'b0 && rd_req_o == 1'b1, "R4", {tag, " polling continues"},
                {done_o, rd_req_o}, 2'b01);
         end
      end
      @(negedge clk);
      chk(done_o == 1'b0, "R8", {tag, " done one cycle"}, done_o, 0);
      chk(rd_req_o == 1'b0, "R8", {tag, " back to idle"}, rd_req_o, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rd_req_o == 1'b0 && done_o == 1'b0, "R1", "reset idle", {rd_req_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_req_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", {rd_req_o, done_o}, 0);

      // R3/R4: two plain misses, then a match, then the capture read; busy start poked (R8).
      rsp = '{8'h05, 8'h01, 8'h80, 8'hA5};
      run("R3 program", 1'b0, 8'hA5, 19'h12345, 1'b1);
      // R5: timeout bit set, recheck matches, capture read.
      rsp = '{8'hA0, 8'h3C, 8'h3D};
      run("R5 recheck pass", 1'b0, 8'h3C, 19'h00100, 1'b0);
      // R6: plain miss, timeout bit, recheck still wrong.
      rsp = '{8'h80, 8'hA0, 8'hE0};
      run("R6 recheck fail", 1'b0, 8'h3C, 19'h7FFFF, 1'b0);
      // R7: erase expects bit 7 = 1 although exp_data_i is 0.
      rsp = '{8'h00, 8'h7F, 8'hFF, 8'hFE};
      run("R7 erase", 1'b1, 8'h00, 19'h40000, 1'b0);
      // R9: LIM misses without timeout bit.
      rsp = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h11, 8'hFF, 8'hFF};
      run("R9 limit", 1'b0, 8'hFF, 19'h00ABC, 1'b0);
      // R3: immediate match.
      rsp = '{8'h80, 8'h5A};
      run("R3 immediate", 1'b0, 8'h80, 19'h00001, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule